// File: doc/BRIEF.md
# Byte-Command Register File Controller

This block sits behind a serial slave front end. It turns framed byte transactions into updates of a small control register array and two 256-byte memories. The front end marks the start of a frame, presents each received byte with a valid strobe, and marks the end of the frame. The first byte of every frame is an opcode, and the bytes after it are its arguments. Arguments are decoded one at a time as they arrive, so no frame buffer is needed. Single-byte read requests are served on their own: each one returns the byte that the current read source's pointer addresses, then advances that pointer.

All transfers go through pointer registers that live inside the register array itself:
- Three read pointers, one for the register array, one for the timing table and one for the storage array.
- Three write pointers for the same three memories.
- A read-source selector and a write-destination selector, which choose the pointer to use.

Sticky error flags record misuse. One opcode copies the whole timing table into the storage array, which models a non-volatile image. The full register array is exported on a flat bus for the actuator logic nearby, together with note-on and note-off strobes.

Top module: `cmd_regfile`

## Requirements
- R1: After synchronous reset, register i appears on `regs_flat[8i+7:8i]` with these values: 5 at index 8, 4 at indices 7 and 10, 127 at index 11, 255 at index 12, 5 at index 13, 14 at index 16, 250 at index 18, and 0 everywhere else, including the read-source selector at index 3.
- R2: Opcode 0 writes its first, second and third argument bytes to registers 11, 12 and 13. Opcode 7 writes its first and second arguments to registers 17 and 18. Opcode 8 writes its first argument to register 19. Each update is visible one cycle after its byte; any extra argument bytes are ignored.
- R3: On `rd_req`, register 3 selects the read source: 0 is the register array through pointer 0, 1 is the table through pointer 1, and 2 is the storage array through pointer 2. `rd_valid` pulses with the data exactly two cycles after `rd_req`, and the pointer then advances by one. A register pointer at 19 or above wraps to 0, and a register index of 20 or above reads as 0. Table and storage pointers wrap modulo 256.
- R4: A read request while register 3 holds a value above 2 produces no `rd_valid` and sets bit 0 (value 0x01) of register 15.
- R5: Opcode 4 copies its first argument into register 3. When that value is 0, 1 or 2, a second argument loads the pointer register it selects.
- R6: Opcode 5 takes the low 3 bits of its first argument as the write destination: 4 is the register array through pointer 4, 5 is the table through pointer 5, and 6 is the storage array through pointer 6. The destination is stored in register 7. If bit 3 of the first argument is set, the next byte loads that pointer. Every further byte is written at the pointer, which then advances with the same wrap rules as in R3. A register write to an index of 20 or above changes nothing except the pointer.
- R7: A write destination outside 4 to 6 sets bit 1 (0x02) of register 15. Register 7 keeps its value and the rest of that frame is ignored.
- R8: Opcode 2 writes its arguments to registers 8, 9 and 10. A first argument larger than register 16 is replaced by the value of register 16 and sets bit 2 (0x04) of register 15. Opcodes 1 and 2 pulse `note_on` for one cycle, one cycle after the `frame_end` cycle.
- R9: Opcode 3 pulses `note_off` for one cycle, one cycle after the `frame_end` cycle, and changes no register.
- R10: Opcode 6 copies all 256 table bytes into the same addresses of the storage array. The copy is complete 260 cycles after `frame_end`.
- R11: Register 14 ignores writes. A write-command byte aimed at register 15 clears all error bits, whatever its value. Apart from that, error bits only ever get set.
- R12: Opcodes of 9 and above, and bytes outside a frame, change no register and pulse no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Opens a frame; the next valid byte is the opcode |
| byte_valid | input | 1 | Qualifies `byte_data` |
| byte_data | input | 8 | Received frame byte |
| frame_end | input | 1 | Closes the frame and fires any strobe or copy |
| rd_req | input | 1 | Single-byte read request |
| rd_data | output | 8 | Read result, valid with `rd_valid` |
| rd_valid | output | 1 | One-cycle pulse two cycles after an accepted request |
| note_on | output | 1 | One-cycle note-on strobe |
| note_off | output | 1 | One-cycle note-off strobe |
| regs_flat | output | NREG*8 | All control registers; register i at bits 8i+7:8i |

## Verification
The bench uses the default parameters: 20 registers and 8-bit table addresses. This makes every wrap boundary reachable with short transfers:
- pointer 19 wrapping to 0,
- reads of register indices past the array,
- table pointers crossing 255 to 0.

Both 256-byte memories are first filled through single long write frames. A table-to-storage copy of all 256 entries can then be compared byte by byte within a few hundred cycles. Random frames of the parameter, delay, write and read-select opcodes are then mixed with random reads, and the whole register array is compared after every step.

// File: rtl/cmd_regfile_pkg.sv
package cmd_regfile_pkg;

  localparam int unsigned BYTE_W = 8;

  // register index map (the decoder relies on these positions)
  localparam int unsigned IDX_RD_REG  = 0;
  localparam int unsigned IDX_RD_TBL  = 1;
  localparam int unsigned IDX_RD_STO  = 2;
  localparam int unsigned IDX_RD_SRC  = 3;
  localparam int unsigned IDX_WR_REG  = 4;
  localparam int unsigned IDX_WR_TBL  = 5;
  localparam int unsigned IDX_WR_STO  = 6;
  localparam int unsigned IDX_WR_DST  = 7;
  localparam int unsigned IDX_COARSE  = 8;
  localparam int unsigned IDX_FINE    = 9;
  localparam int unsigned IDX_PRESC   = 10;
  localparam int unsigned IDX_DUTY    = 11;
  localparam int unsigned IDX_FREQ    = 12;
  localparam int unsigned IDX_PDIV    = 13;
  localparam int unsigned IDX_STATE   = 14;
  localparam int unsigned IDX_ERR     = 15;
  localparam int unsigned IDX_CMAX    = 16;
  localparam int unsigned IDX_DLY_C   = 17;
  localparam int unsigned IDX_DLY_F   = 18;
  localparam int unsigned IDX_FLAGS   = 19;

  localparam logic [7:0] OP_PWM      = 8'd0;
  localparam logic [7:0] OP_NOTE_VEL = 8'd1;
  localparam logic [7:0] OP_NOTE_US  = 8'd2;
  localparam logic [7:0] OP_NOTE_OFF = 8'd3;
  localparam logic [7:0] OP_RD_SEL   = 8'd4;
  localparam logic [7:0] OP_WRITE    = 8'd5;
  localparam logic [7:0] OP_COPY     = 8'd6;
  localparam logic [7:0] OP_HOLD_DLY = 8'd7;
  localparam logic [7:0] OP_FLAGS    = 8'd8;

  localparam logic [7:0] ERR_RD_SRC = 8'h01;
  localparam logic [7:0] ERR_WR_DST = 8'h02;
  localparam logic [7:0] ERR_COARSE = 8'h04;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_TBL = 2'd1,
    SRC_STO = 2'd2
  } src_e;

  function automatic logic [7:0] rst_val(input int unsigned idx);
    case (idx)
      IDX_WR_DST: rst_val = 8'd4;
      IDX_COARSE: rst_val = 8'd5;
      IDX_PRESC:  rst_val = 8'd4;
      IDX_DUTY:   rst_val = 8'd127;
      IDX_FREQ:   rst_val = 8'd255;
      IDX_PDIV:   rst_val = 8'd5;
      IDX_CMAX:   rst_val = 8'd14;
      IDX_DLY_F:  rst_val = 8'd250;
      default:    rst_val = 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/cmd_regfile_ram.sv
module cmd_regfile_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmd_regfile_copy.sv
module cmd_regfile_copy #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    src_q,
  output logic          active,
  output logic [AW-1:0] rd_addr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      we     <= 1'b0;
      waddr  <= '0;
    end else begin
      we    <= active;
      waddr <= cnt;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == LAST) active <= 1'b0;
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rd_addr = cnt;
  assign wdata   = src_q;

  // R10: the copy walk ends right after the last address
  a_r10_copy_ends: assert property (@(posedge clk) disable iff (rst)
    (active && !start && cnt == LAST) |=> !active);

  // R10: every storage write follows a table read
  a_r10_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    we |-> $past(active));
endmodule

// File: rtl/cmd_regfile_ctrl.sv
module cmd_regfile_ctrl
  import cmd_regfile_pkg::*;
#(
  parameter int unsigned NREG = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       frame_end,
  input  logic       rd_req,
  output logic [7:0] regs_q [NREG],
  output logic       rd_ok,
  output logic [1:0] rd_src,
  output logic [7:0] reg_rd_val,
  output logic [7:0] tbl_rd_ptr,
  output logic [7:0] sto_rd_ptr,
  output logic       tbl_we,
  output logic [7:0] tbl_waddr,
  output logic [7:0] tbl_wdata,
  output logic       sto_we,
  output logic [7:0] sto_waddr,
  output logic [7:0] sto_wdata,
  output logic       note_on,
  output logic       note_off,
  output logic       copy_start
);
  localparam int unsigned PW     = $clog2(NREG);
  localparam logic [7:0]  NREG_B = 8'(NREG);
  localparam logic [7:0]  LAST_B = 8'(NREG - 1);

  logic [7:0] regs_d [NREG];
  logic       in_frame, have_op, wr_abort, addr_fl;
  logic [7:0] op_q, arg_idx;
  logic [7:0] err_set;
  logic       err_clr;
  logic       arg_ev;

  function automatic logic [7:0] reg_inc(input logic [7:0] p);
    reg_inc = (p >= LAST_B) ? 8'd0 : p + 8'd1;
  endfunction

  assign arg_ev     = byte_valid && in_frame && have_op;
  assign rd_src     = regs_q[IDX_RD_SRC][1:0];
  assign rd_ok      = rd_req && (regs_q[IDX_RD_SRC] <= 8'd2);
  assign tbl_rd_ptr = regs_q[IDX_RD_TBL];
  assign sto_rd_ptr = regs_q[IDX_RD_STO];
  assign reg_rd_val = (regs_q[IDX_RD_REG] < NREG_B) ?
                      regs_q[regs_q[IDX_RD_REG][PW-1:0]] : 8'd0;

  always_comb begin
    logic [7:0] p;
    for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
    err_set   = '0;
    err_clr   = 1'b0;
    tbl_we    = 1'b0;
    tbl_waddr = regs_q[IDX_WR_TBL];
    tbl_wdata = byte_data;
    sto_we    = 1'b0;
    sto_waddr = regs_q[IDX_WR_STO];
    sto_wdata = byte_data;
    p         = regs_q[IDX_WR_REG];

    // read side: advance the selected pointer
    if (rd_req) begin
      case (regs_q[IDX_RD_SRC])
        8'd0:    regs_d[IDX_RD_REG] = reg_inc(regs_q[IDX_RD_REG]);
        8'd1:    regs_d[IDX_RD_TBL] = regs_q[IDX_RD_TBL] + 8'd1;
        8'd2:    regs_d[IDX_RD_STO] = regs_q[IDX_RD_STO] + 8'd1;
        default: err_set = err_set | ERR_RD_SRC;
      endcase
    end

    // command side: one argument byte per cycle
    if (arg_ev) begin
      case (op_q)
        OP_PWM: begin
          case (arg_idx)
            8'd0: regs_d[IDX_DUTY] = byte_data;
            8'd1: regs_d[IDX_FREQ] = byte_data;
            8'd2: regs_d[IDX_PDIV] = byte_data;
            default: ;
          endcase
        end
        OP_NOTE_US: begin
          case (arg_idx)
            8'd0: begin
              if (byte_data > regs_q[IDX_CMAX]) begin
                regs_d[IDX_COARSE] = regs_q[IDX_CMAX];
                err_set = err_set | ERR_COARSE;
              end else begin
                regs_d[IDX_COARSE] = byte_data;
              end
            end
            8'd1: regs_d[IDX_FINE]  = byte_data;
            8'd2: regs_d[IDX_PRESC] = byte_data;
            default: ;
          endcase
        end
        OP_RD_SEL: begin
          if (arg_idx == 8'd0) begin
            regs_d[IDX_RD_SRC] = byte_data;
          end else if (arg_idx == 8'd1 && regs_q[IDX_RD_SRC] <= 8'd2) begin
            regs_d[regs_q[IDX_RD_SRC][1:0]] = byte_data;
          end
        end
        OP_WRITE: begin
          if (arg_idx == 8'd0) begin
            if (byte_data[2:0] >= 3'd4 && byte_data[2:0] <= 3'd6) begin
              regs_d[IDX_WR_DST] = {5'd0, byte_data[2:0]};
            end else begin
              err_set = err_set | ERR_WR_DST;
            end
          end else if (!wr_abort) begin
            if (arg_idx == 8'd1 && addr_fl) begin
              regs_d[regs_q[IDX_WR_DST][2:0]] = byte_data;
            end else begin
              case (regs_q[IDX_WR_DST])
                8'd4: begin
                  if (p < NREG_B) begin
                    if (p == 8'(IDX_ERR)) err_clr = 1'b1;
                    else if (p != 8'(IDX_STATE)) regs_d[p[PW-1:0]] = byte_data;
                  end
                  regs_d[IDX_WR_REG] = reg_inc(p);
                end
                8'd5: begin
                  tbl_we = 1'b1;
                  regs_d[IDX_WR_TBL] = regs_q[IDX_WR_TBL] + 8'd1;
                end
                8'd6: begin
                  sto_we = 1'b1;
                  regs_d[IDX_WR_STO] = regs_q[IDX_WR_STO] + 8'd1;
                end
                default: ;
              endcase
            end
          end
        end
        OP_HOLD_DLY: begin
          if (arg_idx == 8'd0)      regs_d[IDX_DLY_C] = byte_data;
          else if (arg_idx == 8'd1) regs_d[IDX_DLY_F] = byte_data;
        end
        OP_FLAGS: begin
          if (arg_idx == 8'd0) regs_d[IDX_FLAGS] = byte_data;
        end
        default: ;
      endcase
    end

    regs_d[IDX_ERR] = (err_clr ? 8'd0 : regs_q[IDX_ERR]) | err_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= rst_val(i);
      in_frame   <= 1'b0;
      have_op    <= 1'b0;
      op_q       <= '0;
      arg_idx    <= '0;
      wr_abort   <= 1'b1;
      addr_fl    <= 1'b0;
      note_on    <= 1'b0;
      note_off   <= 1'b0;
      copy_start <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
      note_on    <= 1'b0;
      note_off   <= 1'b0;
      copy_start <= 1'b0;
      if (frame_start) begin
        in_frame <= 1'b1;
        have_op  <= 1'b0;
        arg_idx  <= '0;
        wr_abort <= 1'b1;
      end else if (byte_valid && in_frame) begin
        if (!have_op) begin
          op_q    <= byte_data;
          have_op <= 1'b1;
        end else begin
          if (arg_idx != 8'hFF) arg_idx <= arg_idx + 8'd1;
          if (op_q == OP_WRITE && arg_idx == 8'd0) begin
            wr_abort <= !(byte_data[2:0] >= 3'd4 && byte_data[2:0] <= 3'd6);
            addr_fl  <= byte_data[3];
          end
        end
      end else if (frame_end && in_frame) begin
        in_frame <= 1'b0;
        if (have_op) begin
          case (op_q)
            OP_NOTE_VEL, OP_NOTE_US: note_on <= 1'b1;
            OP_NOTE_OFF:             note_off <= 1'b1;
            OP_COPY:                 copy_start <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  // R3: register read pointer wraps to index 0 past the last register
  a_r3_reg_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (rd_req && regs_q[IDX_RD_SRC] == 8'd0 && regs_q[IDX_RD_REG] >= LAST_B && !arg_ev)
      |=> regs_q[IDX_RD_REG] == 8'd0);

  // R11: error bits never drop without a clearing write
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    !err_clr |=> ((regs_q[IDX_ERR] & $past(regs_q[IDX_ERR])) == $past(regs_q[IDX_ERR])));

  // R8: the coarse value never exceeds the limit after a coarse argument
  a_r8_coarse_clamp: assert property (@(posedge clk) disable iff (rst)
    (arg_ev && op_q == OP_NOTE_US && arg_idx == 8'd0)
      |=> regs_q[IDX_COARSE] <= regs_q[IDX_CMAX]);

  // R8/R9: strobes only follow a frame end, and never together
  a_r9_strobe_after_end: assert property (@(posedge clk) disable iff (rst)
    (note_on || note_off) |-> $past(frame_end));
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({note_on, note_off, copy_start}));
endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import cmd_regfile_pkg::*;
#(
  parameter int unsigned NREG   = 20,
  parameter int unsigned TBL_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              frame_end,
  input  logic              rd_req,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              note_on,
  output logic              note_off,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] regs_q [NREG];
  logic       rd_ok;
  logic [1:0] rd_src;
  logic [7:0] reg_rd_val, tbl_rd_ptr, sto_rd_ptr;
  logic       c_tbl_we, c_sto_we;
  logic [7:0] c_tbl_waddr, c_tbl_wdata, c_sto_waddr, c_sto_wdata;
  logic       copy_start, copy_act, copy_we;
  logic [TBL_AW-1:0] copy_raddr, copy_waddr;
  logic [7:0] copy_wdata;
  logic [7:0] tbl_q, sto_q;
  logic       sto_we;
  logic [TBL_AW-1:0] tbl_raddr, sto_waddr;
  logic [7:0] sto_wdata;

  cmd_regfile_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rst(rst),
    .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .frame_end(frame_end), .rd_req(rd_req),
    .regs_q(regs_q), .rd_ok(rd_ok), .rd_src(rd_src), .reg_rd_val(reg_rd_val),
    .tbl_rd_ptr(tbl_rd_ptr), .sto_rd_ptr(sto_rd_ptr),
    .tbl_we(c_tbl_we), .tbl_waddr(c_tbl_waddr), .tbl_wdata(c_tbl_wdata),
    .sto_we(c_sto_we), .sto_waddr(c_sto_waddr), .sto_wdata(c_sto_wdata),
    .note_on(note_on), .note_off(note_off), .copy_start(copy_start)
  );

  cmd_regfile_copy #(.AW(TBL_AW)) u_copy (
    .clk(clk), .rst(rst), .start(copy_start), .src_q(tbl_q),
    .active(copy_act), .rd_addr(copy_raddr),
    .we(copy_we), .waddr(copy_waddr), .wdata(copy_wdata)
  );

  assign tbl_raddr = copy_act ? copy_raddr : tbl_rd_ptr[TBL_AW-1:0];
  assign sto_we    = copy_we | c_sto_we;
  assign sto_waddr = copy_we ? copy_waddr : c_sto_waddr[TBL_AW-1:0];
  assign sto_wdata = copy_we ? copy_wdata : c_sto_wdata;

  cmd_regfile_ram #(.AW(TBL_AW), .DW(BYTE_W)) u_tbl (
    .clk(clk), .we(c_tbl_we), .waddr(c_tbl_waddr[TBL_AW-1:0]),
    .wdata(c_tbl_wdata), .raddr(tbl_raddr), .rdata(tbl_q)
  );

  cmd_regfile_ram #(.AW(TBL_AW), .DW(BYTE_W)) u_sto (
    .clk(clk), .we(sto_we), .waddr(sto_waddr),
    .wdata(sto_wdata), .raddr(sto_rd_ptr[TBL_AW-1:0]), .rdata(sto_q)
  );

  // two-stage read path: memory register, then output register
  logic       v1;
  logic [1:0] src1;
  logic [7:0] regv1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1       <= 1'b0;
      src1     <= '0;
      regv1    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      v1       <= rd_ok;
      src1     <= rd_src;
      regv1    <= reg_rd_val;
      rd_valid <= v1;
      if (v1) begin
        case (src1)
          SRC_REG: rd_data <= regv1;
          SRC_TBL: rd_data <= tbl_q;
          default: rd_data <= sto_q;
        endcase
      end
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign regs_flat[g*8 +: 8] = regs_q[g];
    end
  endgenerate

  // R3: an accepted read yields data exactly two cycles later
  a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
    (rd_req && regs_q[IDX_RD_SRC] <= 8'd2) |=> ##1 rd_valid);

  // R4: a bad source never yields data
  a_r4_bad_src_silent: assert property (@(posedge clk) disable iff (rst)
    (rd_req && regs_q[IDX_RD_SRC] > 8'd2) |=> ##1 !rd_valid);
endmodule

// File: tb/cmd_regfile_tb.sv
module cmd_regfile_tb;
  localparam int NREG = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 0, byte_valid = 0, frame_end = 0, rd_req = 0;
  logic [7:0] byte_data = 0;
  logic [7:0] rd_data;
  logic rd_valid, note_on, note_off;
  logic [NREG*8-1:0] regs_flat;

  always #5 clk = ~clk;

  cmd_regfile #(.NREG(NREG), .TBL_AW(8)) u_dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .frame_end(frame_end), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .note_on(note_on),
    .note_off(note_off), .regs_flat(regs_flat)
  );

  int checks = 0, errors = 0;
  logic [7:0] m [NREG];
  logic [7:0] mt [256];
  logic [7:0] ms [256];
  logic [7:0] fb [300];
  logic m_abort, m_afl, got_on, got_off;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pinc(input logic [7:0] p);
    return (p >= 8'd19) ? 8'd0 : p + 8'd1;
  endfunction

  function automatic logic [7:0] dut_reg(input int i);
    return regs_flat[i*8 +: 8];
  endfunction

  task automatic check_regs(input string req);
    int bad = -1;
    for (int i = 0; i < NREG; i++) if (bad < 0 && dut_reg(i) !== m[i]) bad = i;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, $sformatf("%s reg%0d", req, bad), dut_reg(bad), m[bad]);
  endtask

  task automatic m_data(input logic [7:0] b);
    logic [7:0] p;
    case (m[7])
      8'd4: begin
        p = m[4];
        if (p < 20) begin
          if (p == 15) m[15] = 0;
          else if (p != 14) m[p] = b;
        end
        m[4] = pinc(p);
      end
      8'd5: begin mt[m[5]] = b; m[5] = m[5] + 1; end
      8'd6: begin ms[m[6]] = b; m[6] = m[6] + 1; end
      default: ;
    endcase
  endtask

  task automatic m_byte(input int k, input logic [7:0] op, input logic [7:0] b);
    case (op)
      8'd0: if (k < 3) m[11 + k] = b;
      8'd2: begin
        if (k == 0) begin
          if (b > m[16]) begin m[8] = m[16]; m[15] = m[15] | 8'h04; end
          else m[8] = b;
        end else if (k == 1) m[9] = b;
        else if (k == 2) m[10] = b;
      end
      8'd4: begin
        if (k == 0) m[3] = b;
        else if (k == 1 && m[3] <= 2) m[m[3]] = b;
      end
      8'd5: begin
        if (k == 0) begin
          if (b[2:0] >= 4 && b[2:0] <= 6) begin
            m[7] = {5'd0, b[2:0]}; m_abort = 0; m_afl = b[3];
          end else begin
            m[15] = m[15] | 8'h02; m_abort = 1;
          end
        end else if (!m_abort) begin
          if (k == 1 && m_afl) m[m[7]] = b;
          else m_data(b);
        end
      end
      8'd7: begin if (k == 0) m[17] = b; else if (k == 1) m[18] = b; end
      8'd8: if (k == 0) m[19] = b;
      default: ;
    endcase
  endtask

  task automatic send(input int n);
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
    m_abort = 1;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1; byte_data = fb[i];
      if (i > 0) m_byte(i - 1, fb[0], fb[i]);
      @(negedge clk);
    end
    byte_valid = 0; frame_end = 1;
    @(negedge clk) frame_end = 0;
    got_on = note_on; got_off = note_off;
    @(negedge clk);
  endtask

  task automatic do_read(input string req);
    logic [7:0] ev = 0;
    logic ok = 1;
    case (m[3])
      8'd0: begin ev = (m[0] < 20) ? m[m[0]] : 8'd0; m[0] = pinc(m[0]); end
      8'd1: begin ev = mt[m[1]]; m[1] = m[1] + 1; end
      8'd2: begin ev = ms[m[2]]; m[2] = m[2] + 1; end
      default: begin ok = 0; m[15] = m[15] | 8'h01; end
    endcase
    @(negedge clk) rd_req = 1;
    @(negedge clk) rd_req = 0;
    @(negedge clk);
    chk(rd_valid == ok, {req, " valid"}, rd_valid, ok);
    if (ok) chk(rd_data == ev, {req, " data"}, rd_data, ev);
  endtask

  task automatic set_src(input logic [7:0] src, input logic [7:0] addr);
    fb[0] = 4; fb[1] = src; fb[2] = addr; send(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NREG; i++) m[i] = 0;
    m[7] = 4; m[8] = 5; m[10] = 4; m[11] = 127; m[12] = 255;
    m[13] = 5; m[16] = 14; m[18] = 250;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_regs("R1 reset");

    // fill both memories: table i^0x5A, storage i+3
    fb[0] = 5; fb[1] = 8'h0D; fb[2] = 0;
    for (int i = 0; i < 256; i++) fb[3 + i] = 8'(i) ^ 8'h5A;
    send(259);
    check_regs("R6 table fill");
    fb[0] = 5; fb[1] = 8'h0E; fb[2] = 0;
    for (int i = 0; i < 256; i++) fb[3 + i] = 8'(i + 3);
    send(259);
    check_regs("R6 storage fill");

    // R2 parameter opcodes
    fb[0] = 0; fb[1] = 8'h11; fb[2] = 8'h22; fb[3] = 8'h33; fb[4] = 8'h44; send(5);
    check_regs("R2 pwm args");
    fb[0] = 7; fb[1] = 8'h09; fb[2] = 8'h7C; send(3);
    fb[0] = 8; fb[1] = 8'h01; send(2);
    check_regs("R2 delay and flags");

    // R6 table write across pointer wrap, then R5/R3 readback
    fb[0] = 5; fb[1] = 8'h0D; fb[2] = 8'd252;
    for (int i = 0; i < 6; i++) fb[3 + i] = 8'hA0 + 8'(i);
    send(9);
    chk(dut_reg(5) == 8'd2, "R6 table ptr wrap", dut_reg(5), 2);
    set_src(1, 8'd253);
    check_regs("R5 read select");
    for (int i = 0; i < 5; i++) do_read("R3 table read wrap");

    // R7 bad destination
    fb[0] = 5; fb[1] = 8'h07; fb[2] = 8'h55; send(3);
    chk(dut_reg(15) == 8'h02, "R7 err bit", dut_reg(15), 2);
    check_regs("R7 dst kept");

    // R8 clamp plus note_on
    fb[0] = 2; fb[1] = 8'd40; fb[2] = 8'd7; fb[3] = 8'd3; send(4);
    chk(got_on == 1, "R8 note_on", got_on, 1);
    chk(dut_reg(8) == 8'd14, "R8 clamp", dut_reg(8), 14);
    check_regs("R8 regs");

    // R11 write to state and error registers
    fb[0] = 5; fb[1] = 8'h0C; fb[2] = 8'd14; fb[3] = 8'hAA; fb[4] = 8'h77; send(5);
    chk(dut_reg(14) == 8'd0, "R11 state ignored", dut_reg(14), 0);
    chk(dut_reg(15) == 8'd0, "R11 err cleared", dut_reg(15), 0);
    check_regs("R11 regs");

    // R6 register write at index past the array
    fb[0] = 5; fb[1] = 8'h0C; fb[2] = 8'd22; fb[3] = 8'h99; send(4);
    chk(dut_reg(4) == 8'd0, "R6 ptr past array", dut_reg(4), 0);
    check_regs("R6 no write past array");

    // R3 register reads across wrap and past the array
    set_src(0, 8'd18);
    for (int i = 0; i < 3; i++) do_read("R3 reg read wrap");
    set_src(0, 8'd21);
    do_read("R3 read past array");

    // R4 bad source
    fb[0] = 4; fb[1] = 8'd3; send(2);
    do_read("R4 bad source");
    chk(dut_reg(15) == 8'h01, "R4 err bit", dut_reg(15), 1);

    // R9 note_off, R8 velocity note_on
    fb[0] = 3; send(1);
    chk(got_off == 1 && got_on == 0, "R9 note_off", got_off, 1);
    fb[0] = 1; fb[1] = 8'd90; send(2);
    chk(got_on == 1, "R8 vel note_on", got_on, 1);
    check_regs("R9 regs");

    // R12 invalid opcodes and stray bytes
    fb[0] = 9; fb[1] = 1; fb[2] = 2; send(3);
    chk(got_on == 0 && got_off == 0, "R12 no strobe", got_on | got_off, 0);
    fb[0] = 8'd200; fb[1] = 8'h0D; send(2);
    @(negedge clk) byte_valid = 1; byte_data = 8'd8;
    @(negedge clk) byte_data = 8'hEE;
    @(negedge clk) byte_valid = 0;
    check_regs("R12 ignored");

    // R10 copy
    fb[0] = 6; send(1);
    for (int i = 0; i < 256; i++) ms[i] = mt[i];
    repeat (262) @(negedge clk);
    set_src(2, 8'd250);
    for (int i = 0; i < 8; i++) do_read("R10 copied storage");

    // random mix
    for (int it = 0; it < 120; it++) begin
      int kind = $urandom_range(0, 6);
      case (kind)
        0: begin fb[0] = 0; for (int i = 1; i < 4; i++) fb[i] = 8'($urandom); send($urandom_range(1, 4)); end
        1: begin fb[0] = 7; fb[1] = 8'($urandom); fb[2] = 8'($urandom); send($urandom_range(1, 3)); end
        2: begin fb[0] = 8; fb[1] = 8'($urandom); send(2); end
        3: begin
          fb[0] = 5; fb[1] = {4'd0, 1'($urandom), ($urandom_range(0, 1) != 0) ? 3'd5 : 3'd6};
          for (int i = 2; i < 7; i++) fb[i] = 8'($urandom);
          send($urandom_range(2, 7));
        end
        4: begin
          logic [7:0] s = 8'($urandom_range(0, 2));
          set_src(s, (s == 0) ? 8'($urandom_range(0, 24)) : 8'($urandom));
        end
        5: begin fb[0] = 2; fb[1] = 8'($urandom_range(0, 30)); fb[2] = 8'($urandom); fb[3] = 8'($urandom); send(4);
          chk(got_on == 1, "R8 random note_on", got_on, 1); end
        default: for (int r = 0; r < 3; r++) do_read("R3 random read");
      endcase
      check_regs("R2 R3 R6 random step");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule